// File: doc/BRIEF.md
# Dual-Rail Command Word Serializer

This block takes a 16-bit command word. Each bit arrives on a pair of wires: one carries the value and the other carries its inverse. A load request captures the word in two phases. First a primary latch in each stage takes the value, then a transfer copies it into a secondary latch that drives the stage output. Once the word is stored, the block compares every stored bit with its input pair. The outcome goes to a match flag. Two faults clear the flag: a pair whose two wires agree (for example, a broken or stuck wire), and a stored bit that differs from the wire.

When the check succeeds, the block is armed and raises busy. A start request then sends the word out one bit at a time, most significant bit first. Each bit is a single pulse on one of two lines: one line for a 0 bit and one line for a 1 bit. Each pulse lasts a programmable number of clock cycles, and a gap of the same length follows it. When the check fails, the block refuses to send and holds an error output until a clear. A clear also resets every stage and aborts a transmission in progress.

Top module: `dualrail_cmd_serializer`

## Requirements
- R1: After reset, and on the edge after `clr_i` is high, `busy_o`, `err_o`, `match_o`, `zero_o` and `one_o` are all low. Clear takes priority over every other request.
- R2: In the idle state, a high `load_i` at a clock edge captures the true rail into the primary latches. The next edge moves them into the secondary latches, and the edge after that records the comparison. The rails must stay unchanged over these three edges. `match_o` is high after the third edge exactly when, in every bit position, the two rails differ and the stored bit equals the true rail.
- R3: When the comparison fails, `match_o` is low, `busy_o` stays low, and `err_o` goes high and stays high until a clear.
- R4: A start request (`start_i` high at an edge) begins shifting only when the block is armed after a successful check. In the idle or error state it produces no pulses.
- R5: Exactly 16 pulses are sent per word, most significant bit first. A 1 bit appears on `one_o` and a 0 bit on `zero_o`, and the two lines are never high together.
- R6: Each pulse lasts `pulse_len_i` cycles and is followed by a low gap of the same number of cycles. The length is sampled at the start request, and a value of 0 acts as 1.
- R7: `busy_o` rises on the edge that records a successful check. It stays high until the end of the last gap, which lies 32 × length cycles after the start edge.
- R8: A `load_i` request while `busy_o` is high is ignored: the word being sent and its pulses are unchanged.
- R9: A clear during shifting stops the pulses from the following edge on, and no further pulses appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all stages and control state |
| rail_t_i | input | 16 | True rail of the command word |
| rail_c_i | input | 16 | Complement rail of the command word |
| load_i | input | 1 | Load request |
| start_i | input | 1 | Start-shifting request |
| pulse_len_i | input | 8 | Pulse and gap length in clock cycles |
| match_o | output | 1 | Stored word agrees with both rails |
| err_o | output | 1 | Load check failed; held until clear |
| busy_o | output | 1 | Armed or shifting |
| zero_o | output | 1 | Pulse line for 0 bits |
| one_o | output | 1 | Pulse line for 1 bits |

## Verification
The hardest fault to produce from the ports is a stored bit that disagrees with a well-formed complementary pair. The latches always copy the true rail, so holding the rails steady never creates one. The stimulus swaps both rails to a different valid word in the cycle between capture and comparison. The comparison then sees correct dual-rail inputs against a stale stored word, and it must still fail. Loads during transmission and clears in mid-pulse are timed against the known pulse schedule.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_CHECK,
    ST_ARMED,
    ST_SEND,
    ST_FAULT
  } dsr_state_t;

  // A bit is sound when its rails differ and the stored copy equals the true rail.
  function automatic logic rail_ok(input logic t, input logic c, input logic q);
    return (t ^ c) & ~(q ^ t);
  endfunction

endpackage

// File: rtl/dsr_stage.sv
module dsr_stage
  import dsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cap_ld,
  input  logic cap_sh,
  input  logic xfer,
  input  logic rail_t,
  input  logic rail_c,
  input  logic shift_in,
  output logic q,
  output logic ok
);

  logic prim;
  logic sec;

  // Phase one: the primary latch takes either the input rail or the neighbour.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prim <= 1'b0;
    else if (clr)    prim <= 1'b0;
    else if (cap_ld) prim <= rail_t;
    else if (cap_sh) prim <= shift_in;
  end

  // Phase two: the transfer clock copies it into the output latch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sec <= 1'b0;
    else if (clr)  sec <= 1'b0;
    else if (xfer) sec <= prim;
  end

  assign q  = sec;
  assign ok = rail_ok(rail_t, rail_c, sec);

  // R2
  xfer_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && !clr |=> q == $past(prim));

endmodule

// File: rtl/dsr_pacer.sv
module dsr_pacer #(
  parameter int W  = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          go,
  input  logic [LW-1:0] len_i,
  output logic          run,
  output logic          hi,
  output logic          end_hi,
  output logic          end_gap,
  output logic          last_bit
);

  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam int CW = LW + 1;

  logic [CW-1:0] cnt;
  logic [LW-1:0] len_q;
  logic [BW-1:0] bitn;
  logic [CW-1:0] half;
  logic [CW-1:0] whole;

  function automatic logic [LW-1:0] eff_len(input logic [LW-1:0] l);
    return (l == '0) ? LW'(1) : l;
  endfunction

  assign half     = {1'b0, len_q};
  assign whole    = {len_q, 1'b0};
  assign hi       = run && (cnt < half);
  assign end_hi   = run && (cnt == half - CW'(1));
  assign end_gap  = run && (cnt == whole - CW'(1));
  assign last_bit = (bitn == BW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; cnt <= '0; bitn <= '0; len_q <= LW'(1);
    end else if (clr) begin
      run <= 1'b0; cnt <= '0; bitn <= '0;
    end else if (go) begin
      run <= 1'b1; cnt <= '0; bitn <= '0; len_q <= eff_len(len_i);
    end else if (run) begin
      if (end_gap) begin
        cnt  <= '0;
        bitn <= bitn + BW'(1);
        if (last_bit) run <= 1'b0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R6
  phase_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({end_hi, end_gap}));

  // R6
  next_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_gap && !last_bit && !clr && !go |=> hi);

endmodule

// File: rtl/dualrail_cmd_serializer.sv
module dualrail_cmd_serializer
  import dsr_pkg::*;
#(
  parameter int W  = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [W-1:0]  rail_t_i,
  input  logic [W-1:0]  rail_c_i,
  input  logic          load_i,
  input  logic          start_i,
  input  logic [LW-1:0] pulse_len_i,
  output logic          match_o,
  output logic          err_o,
  output logic          busy_o,
  output logic          zero_o,
  output logic          one_o
);

  dsr_state_t st;
  logic [W-1:0] q_v;
  logic [W-1:0] ok_v;
  logic cap_ld, cap_sh, xfer, chk_evt, all_ok, go;
  logic pac_run, pac_hi, pac_end_hi, pac_end_gap, pac_last;

  assign cap_ld  = (st == ST_IDLE) && load_i && !clr_i;
  assign chk_evt = (st == ST_CHECK);
  assign go      = (st == ST_ARMED) && start_i && !clr_i;
  assign cap_sh  = pac_end_hi;
  assign xfer    = (st == ST_XFER) || pac_end_gap;
  assign all_ok  = &ok_v;

  for (genvar i = 0; i < W; i++) begin : g_stage
    logic sin;
    if (i == 0) begin : g_head
      assign sin = 1'b0;
    end else begin : g_link
      assign sin = q_v[i-1];
    end
    dsr_stage u_stage (
      .clk(clk), .rst_n(rst_n), .clr(clr_i),
      .cap_ld(cap_ld), .cap_sh(cap_sh), .xfer(xfer),
      .rail_t(rail_t_i[i]), .rail_c(rail_c_i[i]),
      .shift_in(sin), .q(q_v[i]), .ok(ok_v[i])
    );
  end

  dsr_pacer #(.W(W), .LW(LW)) u_pacer (
    .clk(clk), .rst_n(rst_n), .clr(clr_i), .go(go), .len_i(pulse_len_i),
    .run(pac_run), .hi(pac_hi), .end_hi(pac_end_hi),
    .end_gap(pac_end_gap), .last_bit(pac_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
    end else if (clr_i) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_IDLE:  if (cap_ld) st <= ST_XFER;
        ST_XFER:  st <= ST_CHECK;
        ST_CHECK: st <= all_ok ? ST_ARMED : ST_FAULT;
        ST_ARMED: if (go) st <= ST_SEND;
        ST_SEND:  if (pac_end_gap && pac_last) st <= ST_IDLE;
        default:  st <= st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       match_o <= 1'b0;
    else if (clr_i)   match_o <= 1'b0;
    else if (cap_ld)  match_o <= 1'b0;
    else if (chk_evt) match_o <= all_ok;
  end

  assign busy_o = (st == ST_ARMED) || (st == ST_SEND);
  assign err_o  = (st == ST_FAULT);
  assign zero_o = pac_hi && !q_v[W-1];
  assign one_o  = pac_hi && q_v[W-1];

  // R1
  clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !busy_o && !err_o && !match_o && !zero_o && !one_o);

  // R3
  mismatch_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_evt && !all_ok && !clr_i |=> err_o && !busy_o && !match_o);

  // R3
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o && !clr_i |=> err_o);

  // R5
  pulse_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o || one_o) |-> busy_o && pac_run);

  // R7
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pac_end_gap && pac_last && !clr_i |=> !busy_o);

  // R8
  load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && load_i && !start_i && !clr_i && !pac_end_gap && !pac_end_hi
    |=> busy_o && $stable(q_v));

endmodule

// File: tb/tb_dualrail_cmd_serializer.sv
`timescale 1ns/1ps
module tb_dualrail_cmd_serializer;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_i = 1'b0;
  logic [15:0] rail_t_i = '0;
  logic [15:0] rail_c_i = '0;
  logic load_i = 1'b0;
  logic start_i = 1'b0;
  logic [7:0] pulse_len_i = 8'd1;
  logic match_o, err_o, busy_o, zero_o, one_o;

  always #2 clk = ~clk;

  dualrail_cmd_serializer dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
    .rail_t_i(rail_t_i), .rail_c_i(rail_c_i),
    .load_i(load_i), .start_i(start_i), .pulse_len_i(pulse_len_i),
    .match_o(match_o), .err_o(err_o), .busy_o(busy_o),
    .zero_o(zero_o), .one_o(one_o)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit exp_q[$];
  int exp_len = 1;
  bit ign_width = 0;
  int npulse = 0;

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected bit per rising pulse and times pulses and gaps.
  bit pz = 0, po = 0, gap_valid = 0;
  int hw = 0, gap = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (zero_o && one_o) chk(0, "R5 both lines high", 1, 0);
      if ((zero_o || one_o) && !(pz || po)) begin
        npulse++;
        if (exp_q.size() == 0) chk(0, "R5 unexpected pulse", int'(one_o), -1);
        else begin
          bit e;
          e = exp_q.pop_front();
          chk(one_o == e, "R5 bit value/order", int'(one_o), int'(e));
        end
        if (gap_valid) chk(gap == exp_len, "R6 gap length", gap, exp_len);
        hw = 1;
      end else if (zero_o || one_o) begin
        hw++;
      end else if (pz || po) begin
        if (!ign_width) chk(hw == exp_len, "R6 pulse width", hw, exp_len);
        gap = 1;
        gap_valid = 1;
      end else begin
        gap++;
      end
      if (!busy_o) gap_valid = 0;
      pz = zero_o;
      po = one_o;
    end
  end

  task automatic do_load(input logic [15:0] t, input logic [15:0] c);
    @(negedge clk); rail_t_i = t; rail_c_i = c; load_i = 1'b1;
    @(negedge clk); load_i = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic send_word(input logic [15:0] w, input logic [7:0] len, input bit poke);
    int n;
    do_load(w, ~w);
    chk(match_o == 1'b1, "R2 match after clean load", int'(match_o), 1);
    chk(busy_o == 1'b1, "R7 busy after good check", int'(busy_o), 1);
    exp_len = (len == 0) ? 1 : int'(len);
    for (int i = 15; i >= 0; i--) exp_q.push_back(w[i]);
    pulse_len_i = len;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0; pulse_len_i = 8'd7;
    n = 0;
    while (busy_o && n < 10000) begin
      n++;
      if (poke && n == 5) begin rail_t_i = ~w; rail_c_i = w; load_i = 1'b1; end
      if (poke && n == 6) load_i = 1'b0;
      @(negedge clk);
    end
    chk(n == 32 * exp_len, "R7 busy duration", n, 32 * exp_len);
    chk(exp_q.size() == 0, "R5 all 16 pulses sent", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy_o, err_o, match_o, zero_o, one_o} == 5'b0, "R1 reset state",
        int'({busy_o, err_o, match_o, zero_o, one_o}), 0);

    // R4: start in idle does nothing
    p0 = npulse;
    @(negedge clk); start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (10) @(negedge clk);
    chk(npulse == p0 && !busy_o, "R4 start ignored in idle", npulse - p0, 0);

    send_word(16'hA5C3, 8'd1, 0);
    send_word(16'h0000, 8'd3, 0);
    send_word(16'hFFFF, 8'd2, 0);
    send_word(16'h8001, 8'd0, 0);   // R6 zero acts as one
    send_word(16'h3C96, 8'd2, 1);   // R8 load while busy ignored
    repeat (3) @(negedge clk);
    chk(!busy_o && !match_o == 1'b0, "R8 no load taken while busy", int'(busy_o), 0);

    // R3: a pair whose rails agree
    do_load(16'h1234, ~16'h1234 ^ 16'h0020);
    chk(match_o == 1'b0, "R3 match low on stuck pair", int'(match_o), 0);
    chk(err_o == 1'b1 && busy_o == 1'b0, "R3 error raised, not busy",
        int'({err_o, busy_o}), 2);
    p0 = npulse;
    @(negedge clk); start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (12) @(negedge clk);
    chk(npulse == p0 && err_o, "R4 start ignored in fault", npulse - p0, 0);
    @(negedge clk); clr_i = 1'b1; @(negedge clk); clr_i = 1'b0;
    chk(!err_o && !match_o && !busy_o, "R1 clear leaves fault", int'(err_o), 0);

    // R2: rails swapped to another valid word before the check
    @(negedge clk); rail_t_i = 16'h00FF; rail_c_i = 16'hFF00; load_i = 1'b1;
    @(negedge clk); load_i = 1'b0; rail_t_i = 16'h0F0F; rail_c_i = 16'hF0F0;
    @(negedge clk); @(negedge clk);
    chk(match_o == 1'b0 && err_o == 1'b1, "R2 stale stored word mismatches",
        int'(match_o), 0);
    @(negedge clk); clr_i = 1'b1; @(negedge clk); clr_i = 1'b0;

    // R1: clear while armed, then start does nothing
    do_load(16'h5555, 16'hAAAA);
    chk(busy_o == 1'b1, "R7 armed after load", int'(busy_o), 1);
    @(negedge clk); clr_i = 1'b1; @(negedge clk); clr_i = 1'b0;
    chk(!busy_o && !match_o, "R1 clear while armed", int'(busy_o), 0);
    p0 = npulse;
    @(negedge clk); start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (10) @(negedge clk);
    chk(npulse == p0, "R4 start after clear ignored", npulse - p0, 0);

    // R9: clear in mid-transmission
    do_load(16'hF00F, 16'h0FF0);
    exp_len = 2;
    for (int i = 15; i >= 0; i--) exp_q.push_back(logic'(16'hF00F >> i));
    pulse_len_i = 8'd2;
    @(negedge clk); start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (20) @(negedge clk);
    ign_width = 1;
    clr_i = 1'b1; @(negedge clk); clr_i = 1'b0;
    exp_q.delete();
    p0 = npulse;
    chk(!busy_o && !zero_o && !one_o, "R9 clear stops shifting",
        int'({busy_o, zero_o, one_o}), 0);
    repeat (20) @(negedge clk);
    chk(npulse == p0, "R9 no pulses after clear", npulse - p0, 0);
    ign_width = 0;

    send_word(16'h6D21, 8'd4, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule